// File: doc/BRIEF.md
# Soft Mute and Decoder Mute Sequencer

This block sequences the muting of an audio path. When a mute is requested it walks a gain code down from full scale to zero along an S-shaped curve, slow at both ends and fast in the middle. When the request is withdrawn it walks the code back up. The code drives a volume-stage attenuator outside the block. A request comes from an active-low pin or from a control bit. A 2-bit slope code sets how long each step of the curve lasts, and so the total ramp time.

The block also drives the hard-mute line of the FM decoder. When the decoder is the selected source and coupling is enabled, the decoder is silenced only once the audio ramp has reached full mute. It is released in the same cycle that the audio begins to rise again. A separate force bit, or the selection of any other source, holds the decoder muted regardless of the ramp. An independent timer produces a fixed-length mute window for the offset-cancellation stage. A single start pulse opens this window.

Top module: `softmute_seq`

## Requirements
- R1: A mute request is present when `mute_pin_n` is 0 or `mute_bit` is 1. Either one alone starts a falling ramp from the unmuted rest state. A rising ramp starts from full mute once both are inactive.
- R2: The gain code is a function of a ramp position p in 0..NSTEPS: floor((2^GAIN_W-1)·(3p²·N − 2p³)/N³) with N = NSTEPS. A falling ramp moves p from NSTEPS to 0 one step at a time, and a rising ramp moves it from 0 to NSTEPS.
- R3: A ramp that has started runs to its end even if the request changes partway through. The request is looked at again only once the ramp has ended.
- R4: `busy` is 1 from the cycle after a mute request is accepted until the rising ramp reaches full gain. Whenever `busy` is 0 the gain is 2^GAIN_W-1.
- R5: With the decoder selected, coupling on and no force, `dec_mute` rises in the same cycle that the gain first reads 0 at the end of a falling ramp, and never while the gain is non-zero.
- R6: With the decoder selected, coupling on and no force, `dec_mute` falls in the first cycle of the rising ramp. At that point the gain is still 0 and `busy` is 1.
- R7: With `couple_en` at 0 and the decoder selected without force, `dec_mute` stays 0 even at full mute.
- R8: `dec_force` at 1 makes `dec_mute` 1 whatever the ramp state.
- R9: `src_is_dec` at 0 makes `dec_mute` 1.
- R10: A one-cycle `az_start` pulse makes `az_mute` 1 for exactly AZ_CYCLES cycles, starting at the next clock edge. A new pulse inside the window restarts the full count.
- R11: Each ramp step lasts STEP_BASE·2^s cycles, where s is `slope_sel` captured when the ramp starts. A ramp therefore lasts NSTEPS times that.
- R12: After reset the gain is 2^GAIN_W-1, `busy` is 0 and `az_mute` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mute_pin_n | input | 1 | Active-low external mute request |
| mute_bit | input | 1 | Control-bit mute request |
| slope_sel | input | 2 | Step duration code, captured at ramp start |
| couple_en | input | 1 | Links decoder mute to the soft mute |
| dec_force | input | 1 | Forces decoder mute |
| src_is_dec | input | 1 | 1 when the decoder is the selected source |
| az_start | input | 1 | Starts or restarts the auto-zero mute window |
| gain | output | GAIN_W | Gain code for the volume stage |
| busy | output | 1 | Mute sequence in progress |
| dec_mute | output | 1 | Decoder hard-mute line |
| az_mute | output | 1 | Auto-zero mute window |

## Verification
The assertions assume that the inputs change only between clock edges and that the mode inputs are stable at each sampled edge. They also assume that `az_start` is the only thing that can open the auto-zero window. The stimulus drives every input on the falling clock edge. Its random phase toggles requests, slope code and decoder controls at low rates, so that ramps are often cut across by request changes. A bench model, written from the requirements, predicts every output cycle by cycle.

// File: rtl/smute_pkg.sv
package smute_pkg;

    typedef enum logic [1:0] {
        SM_OPEN = 2'd0,
        SM_FALL = 2'd1,
        SM_SHUT = 2'd2,
        SM_RISE = 2'd3
    } smute_state_e;

    // Smoothstep over n positions scaled to top.
    function automatic longint s_curve(longint p, longint n, longint top);
        return (top * (3 * p * p * n - 2 * p * p * p)) / (n * n * n);
    endfunction

endpackage

// File: rtl/smute_curve.sv
module smute_curve
    import smute_pkg::*;
#(
    parameter int GAIN_W = 8,
    parameter int NSTEPS = 16,
    localparam int POS_W = $clog2(NSTEPS + 1)
) (
    input  logic [POS_W-1:0]  pos,
    output logic [GAIN_W-1:0] gain
);
    localparam longint TOP = (longint'(1) << GAIN_W) - 1;

    logic [GAIN_W-1:0] tbl [NSTEPS+1];

    for (genvar k = 0; k <= NSTEPS; k++) begin : g_tbl
        assign tbl[k] = GAIN_W'(s_curve(longint'(k), longint'(NSTEPS), TOP));
    end

    always_comb begin
        if (int'(pos) > NSTEPS) gain = {GAIN_W{1'b1}};
        else                    gain = tbl[pos];
    end
endmodule

// File: rtl/smute_ramp_fsm.sv
module smute_ramp_fsm
    import smute_pkg::*;
#(
    parameter int NSTEPS    = 16,
    parameter int STEP_BASE = 64,
    localparam int POS_W = $clog2(NSTEPS + 1),
    localparam int CNT_W = $clog2(STEP_BASE * 8) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [1:0]       slope_sel,
    output logic [POS_W-1:0] pos,
    output smute_state_e     state
);
    typedef struct packed {
        smute_state_e     state;
        logic [POS_W-1:0] pos;
        logic [CNT_W-1:0] cnt;
        logic [1:0]       slope;
    } ramp_t;

    ramp_t ramp_d, ramp_q;
    logic [CNT_W-1:0] step_len;
    logic             step_end;

    always_comb begin
        ramp_d   = ramp_q;
        step_len = CNT_W'(STEP_BASE) << ramp_q.slope;
        step_end = (ramp_q.cnt == step_len - CNT_W'(1));
        case (ramp_q.state)
            SM_OPEN: if (req) begin
                ramp_d.state = SM_FALL;
                ramp_d.cnt   = '0;
                ramp_d.slope = slope_sel;
            end
            SM_FALL: if (step_end) begin
                ramp_d.cnt = '0;
                ramp_d.pos = ramp_q.pos - POS_W'(1);
                if (ramp_q.pos == POS_W'(1)) ramp_d.state = SM_SHUT;
            end else begin
                ramp_d.cnt = ramp_q.cnt + CNT_W'(1);
            end
            SM_SHUT: if (!req) begin
                ramp_d.state = SM_RISE;
                ramp_d.cnt   = '0;
                ramp_d.slope = slope_sel;
            end
            SM_RISE: if (step_end) begin
                ramp_d.cnt = '0;
                ramp_d.pos = ramp_q.pos + POS_W'(1);
                if (ramp_q.pos == POS_W'(NSTEPS - 1)) ramp_d.state = SM_OPEN;
            end else begin
                ramp_d.cnt = ramp_q.cnt + CNT_W'(1);
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ramp_q.state <= SM_OPEN;
            ramp_q.pos   <= POS_W'(NSTEPS);
            ramp_q.cnt   <= '0;
            ramp_q.slope <= '0;
        end else begin
            ramp_q <= ramp_d;
        end
    end

    assign pos   = ramp_q.pos;
    assign state = ramp_q.state;
endmodule

// File: rtl/smute_az_timer.sv
module smute_az_timer #(
    parameter int AZ_CYCLES = 75000,
    localparam int AZ_W = $clog2(AZ_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic active
);
    typedef struct packed {
        logic [AZ_W-1:0] left;
    } az_t;

    az_t az_d, az_q;

    always_comb begin
        az_d = az_q;
        if (start)                 az_d.left = AZ_W'(AZ_CYCLES);
        else if (az_q.left != '0)  az_d.left = az_q.left - AZ_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) az_q.left <= '0;
        else        az_q      <= az_d;
    end

    assign active = (az_q.left != '0);
endmodule

// File: rtl/softmute_seq.sv
module softmute_seq
    import smute_pkg::*;
#(
    parameter int GAIN_W    = 8,
    parameter int NSTEPS    = 16,
    parameter int STEP_BASE = 64,
    parameter int AZ_CYCLES = 75000,
    localparam int POS_W = $clog2(NSTEPS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mute_pin_n,
    input  logic              mute_bit,
    input  logic [1:0]        slope_sel,
    input  logic              couple_en,
    input  logic              dec_force,
    input  logic              src_is_dec,
    input  logic              az_start,
    output logic [GAIN_W-1:0] gain,
    output logic              busy,
    output logic              dec_mute,
    output logic              az_mute
);
    logic             req;
    logic [POS_W-1:0] pos;
    smute_state_e     state;

    assign req = !mute_pin_n || mute_bit;

    smute_ramp_fsm #(.NSTEPS(NSTEPS), .STEP_BASE(STEP_BASE)) i_fsm (
        .clk(clk), .rst_n(rst_n), .req(req), .slope_sel(slope_sel),
        .pos(pos), .state(state)
    );

    smute_curve #(.GAIN_W(GAIN_W), .NSTEPS(NSTEPS)) i_curve (
        .pos(pos), .gain(gain)
    );

    smute_az_timer #(.AZ_CYCLES(AZ_CYCLES)) i_az (
        .clk(clk), .rst_n(rst_n), .start(az_start), .active(az_mute)
    );

    assign busy     = (state != SM_OPEN);
    assign dec_mute = dec_force || !src_is_dec || (couple_en && state == SM_SHUT);
endmodule

// File: rtl/smute_chk.sv
module smute_chk
    import smute_pkg::*;
#(
    parameter int GAIN_W = 8,
    parameter int POS_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [GAIN_W-1:0] gain,
    input logic              busy,
    input logic              dec_mute,
    input logic              az_mute,
    input logic              az_start,
    input logic              src_is_dec,
    input logic              dec_force,
    input smute_state_e      state,
    input logic [POS_W-1:0]  pos
);
    assert_fall_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        state == SM_FALL |=> (state == SM_FALL || state == SM_SHUT));

    assert_rise_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        state == SM_RISE |=> (state == SM_RISE || state == SM_OPEN));

    assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state == SM_FALL |=> (pos == $past(pos) || pos == $past(pos) - POS_W'(1)));

    assert_idle_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> gain == {GAIN_W{1'b1}});

    assert_dec_after_ramp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (src_is_dec && !dec_force && gain != '0) |-> !dec_mute);

    assert_force_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_force |-> dec_mute);

    assert_other_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !src_is_dec |-> dec_mute);

    assert_az_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(az_mute) |-> $past(az_start));
endmodule

bind softmute_seq smute_chk #(.GAIN_W(GAIN_W), .POS_W(POS_W)) i_smute_chk (
    .clk(clk), .rst_n(rst_n), .gain(gain), .busy(busy), .dec_mute(dec_mute),
    .az_mute(az_mute), .az_start(az_start), .src_is_dec(src_is_dec),
    .dec_force(dec_force), .state(state), .pos(pos)
);

// File: tb/test_softmute_seq.sv
module test_softmute_seq;
    localparam int GW = 8;
    localparam int NS = 16;
    localparam int SB = 3;
    localparam int AZ = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mute_pin_n = 1'b1, mute_bit = 1'b0, couple_en = 1'b1;
    logic dec_force = 1'b0, src_is_dec = 1'b1, az_start = 1'b0;
    logic [1:0] slope_sel = 2'd0;
    logic [GW-1:0] gain;
    logic busy, dec_mute, az_mute;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    softmute_seq #(.GAIN_W(GW), .NSTEPS(NS), .STEP_BASE(SB), .AZ_CYCLES(AZ)) i_softmute_seq (
        .clk(clk), .rst_n(rst_n), .mute_pin_n(mute_pin_n), .mute_bit(mute_bit),
        .slope_sel(slope_sel), .couple_en(couple_en), .dec_force(dec_force),
        .src_is_dec(src_is_dec), .az_start(az_start), .gain(gain), .busy(busy),
        .dec_mute(dec_mute), .az_mute(az_mute)
    );

    // Behaviour model: 0 rest, 1 falling, 2 full mute, 3 rising
    int m_st = 0, m_pos = NS, m_cnt = 0, m_len = SB, m_az = 0;

    function automatic int exp_curve(int p);
        return (255 * (48 * p * p - 2 * p * p * p)) / 4096;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_pos = NS; m_cnt = 0; m_len = SB; m_az = 0;
        end else begin
            bit rq;
            rq = !mute_pin_n || mute_bit;
            case (m_st)
                0: if (rq) begin m_st = 1; m_cnt = 0; m_len = SB << slope_sel; end
                1: if (m_cnt == m_len - 1) begin
                       m_cnt = 0; m_pos--; if (m_pos == 0) m_st = 2;
                   end else m_cnt++;
                2: if (!rq) begin m_st = 3; m_cnt = 0; m_len = SB << slope_sel; end
                default: if (m_cnt == m_len - 1) begin
                       m_cnt = 0; m_pos++; if (m_pos == NS) m_st = 0;
                   end else m_cnt++;
            endcase
            if (az_start) m_az = AZ;
            else if (m_az > 0) m_az--;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cmp_all();
        int eg;
        bit ed;
        eg = exp_curve(m_pos);
        ed = dec_force || !src_is_dec || (couple_en && m_st == 2);
        chk(gain == GW'(eg), "R2 gain", gain, eg);
        chk(busy == (m_st != 0), "R4 busy", busy, m_st != 0);
        chk(dec_mute == ed, "R5 dec_mute", dec_mute, ed);
        chk(az_mute == (m_az > 0), "R10 az_mute", az_mute, m_az > 0);
    endtask

    task automatic tick();
        @(negedge clk);
        cmp_all();
    endtask

    task automatic wait_idle();
        int n = 0;
        while ((busy || gain != 8'hFF) && n < 5000) begin tick(); n++; end
    endtask

    task automatic report();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            report();
        end
    end

    initial begin
        int n;
        void'($urandom(1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        tick();
        // R12 reset state
        chk(gain == 8'hFF, "R12 gain", gain, 255);
        chk(!busy, "R12 busy", busy, 0);
        chk(!az_mute, "R12 az_mute", az_mute, 0);

        // R1 pin alone, R11 slope 0 length, R5 coupling
        mute_pin_n = 1'b0;
        n = 0;
        do begin tick(); if (busy && gain != 0) n++; end while (gain != 0 && n < 5000);
        chk(n == NS * SB, "R11 ramp length s0", n, NS * SB);
        chk(dec_mute, "R5 dec_mute at full mute", dec_mute, 1);
        mute_pin_n = 1'b1;
        tick();
        chk(!dec_mute && busy && gain == 0, "R6 immediate release", dec_mute, 0);
        wait_idle();

        // R1 bit alone, slope 2, R3 withdrawn mid ramp
        mute_bit = 1'b1; slope_sel = 2'd2;
        tick();
        chk(busy, "R1 bit starts ramp", busy, 1);
        repeat (5) tick();
        mute_bit = 1'b0; slope_sel = 2'd0;
        n = 6;
        while (gain != 0 && n < 5000) begin tick(); n++; end
        chk(n == NS * (SB << 2) + 1, "R3 ramp ran to end", n, NS * (SB << 2) + 1);
        wait_idle();

        // R7 coupling off
        couple_en = 1'b0; mute_bit = 1'b1;
        n = 0;
        while (!(busy && gain == 0) && n < 5000) begin tick(); n++; end
        tick();
        chk(!dec_mute, "R7 no link", dec_mute, 0);
        mute_bit = 1'b0; couple_en = 1'b1;
        wait_idle();

        // R8 force, R9 other source
        dec_force = 1'b1; tick();
        chk(dec_mute && !busy, "R8 force", dec_mute, 1);
        dec_force = 1'b0; src_is_dec = 1'b0; tick();
        chk(dec_mute, "R9 other source", dec_mute, 1);
        src_is_dec = 1'b1; tick();

        // R10 window length and restart
        az_start = 1'b1; tick(); az_start = 1'b0;
        n = 1;
        while (az_mute && n < 1000) begin tick(); if (az_mute) n++; end
        chk(n == AZ, "R10 window length", n, AZ);
        az_start = 1'b1; tick(); az_start = 1'b0;
        repeat (9) tick();
        az_start = 1'b1; tick(); az_start = 1'b0;
        n = 11;
        while (az_mute && n < 1000) begin tick(); if (az_mute) n++; end
        chk(n == 10 + AZ, "R10 restart", n, 10 + AZ);

        // Random phase against the model
        for (int i = 0; i < 6000; i++) begin
            tick();
            if ($urandom_range(0, 99) < 3) mute_pin_n = ~mute_pin_n;
            if ($urandom_range(0, 99) < 3) mute_bit = ~mute_bit;
            if ($urandom_range(0, 99) < 5) slope_sel = 2'($urandom_range(0, 3));
            if ($urandom_range(0, 99) < 2) couple_en = ~couple_en;
            if ($urandom_range(0, 99) < 2) dec_force = ~dec_force;
            if ($urandom_range(0, 99) < 2) src_is_dec = ~src_is_dec;
            az_start = ($urandom_range(0, 199) == 0);
        end
        done = 1;
        report();
    end
endmodule